// File: doc/BRIEF.md
# I2C Single-Master Step Engine

This block runs one side of an I2C bus as the only master. Software talks to it through three 8-bit registers: a data register, a control register and a status register. A write to control asks for one bus step: a start (or repeated start), a stop, or one byte transfer with its acknowledge slot. The engine performs that step on the open-drain lines, then raises an interrupt flag in control and posts an 8-bit code in status that says how the step ended. Software reads the code, sets up the next step, and writes control again with the flag bit clear to let the engine move on.

Bus timing comes from a `tick` input. Each bit, start and stop takes four ticks, so the rate of `tick` sets the SCL rate. The lines are modelled as "drive low" outputs and an SDA input. The first byte after a start is the address byte. Its bit 0 selects read or write for the bytes that follow. While the flag is set the engine holds SCL low, which keeps the bus paused.

Top module: `i2c_step_engine`

## Requirements
- R1: After reset, control reads 0x00 and status reads 0xF8. Neither bus line is driven low.
- R2: A control write with STA (bit 5) and ENAB (bit 6) set while the bus is not owned gives a start: SDA falls while SCL is high. The engine then sets IFLG (bit 3), clears STA and posts 0x08.
- R3: The same request while the bus is already owned gives a repeated start and posts 0x10.
- R4: After a start, a control write with only ENAB set sends the data register MSB first as the address byte. With bit 0 = 0 (write), the engine posts 0x18 when the target ACKs and 0x20 when it NAKs.
- R5: An address byte with bit 0 = 1 (read) posts 0x40 on ACK and 0x48 on NAK.
- R6: After a write address, each data byte sent posts 0x28 on ACK and 0x30 on NAK.
- R7: After a read address, each step receives one byte into the data register. The engine returns ACK and posts 0x50 when AAK (bit 2) is set. It returns NAK and posts 0x58 when AAK is clear.
- R8: A control write with STP (bit 4) and ENAB set gives a stop: SDA rises while SCL is high. Afterwards STP is clear, IFLG stays clear, status reads 0xF8 and both lines are released.
- R9: If SDA reads low while the engine releases it high during an SCL-high phase of an address or data bit, the engine posts 0x38, sets IFLG, releases both lines and gives up ownership.
- R10: If SDA is held low when a start tries to pull it low, the engine posts 0x00 (bus error), sets IFLG and releases both lines.
- R11: While IFLG is set and the bus is owned, SCL is held low. A control write that leaves IFLG set (bit 3 written 1) starts no bus action and changes no status.
- R12: A control write with ENAB clear starts no bus action.
- R13: Status only ever holds one of the thirteen codes named above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Quarter-bit timing strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 data, 1 control |
| reg_wdata | input | DATA_W | Write value |
| data_o | output | DATA_W | Data register (received byte after a read step) |
| ctl_o | output | 8 | Control register: CE 7, ENAB 6, STA 5, STP 4, IFLG 3, AAK 2 |
| status_o | output | 8 | Status code of the last step |
| scl_low_o | output | 1 | Drive SCL low |
| sda_low_o | output | 1 | Drive SDA low |
| sda_i | input | 1 | Sensed SDA line level |

## Verification
A behavioural target on the bench watches the resolved lines. It records start and stop events and captures the bytes it receives. It ACKs or NAKs the address and data slots as each test requests, and it serves queued read bytes. Write and read addresses are each tried with both acknowledge answers, which separates the four address codes. Data bytes with alternating bit patterns show MSB-first order and the 0x28/0x30 split. Two reads, one with AAK and one without, show that the returned acknowledge follows AAK. A forced-low SDA during a 1 bit of the address must give the arbitration code. The same force during a start request must give the bus-error code, which proves the two failure paths stay separate.

// File: rtl/ibe_pkg.sv
package ibe_pkg;

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_BIT} bit_op_e;
  typedef enum logic [1:0] {K_AW, K_AR, K_TX, K_RX} xfer_e;

  localparam logic [7:0] ST_BERR   = 8'h00;
  localparam logic [7:0] ST_START  = 8'h08;
  localparam logic [7:0] ST_RSTART = 8'h10;
  localparam logic [7:0] ST_AW_ACK = 8'h18;
  localparam logic [7:0] ST_AW_NAK = 8'h20;
  localparam logic [7:0] ST_TX_ACK = 8'h28;
  localparam logic [7:0] ST_TX_NAK = 8'h30;
  localparam logic [7:0] ST_ARB    = 8'h38;
  localparam logic [7:0] ST_AR_ACK = 8'h40;
  localparam logic [7:0] ST_AR_NAK = 8'h48;
  localparam logic [7:0] ST_RX_ACK = 8'h50;
  localparam logic [7:0] ST_RX_NAK = 8'h58;
  localparam logic [7:0] ST_IDLE   = 8'hF8;

  localparam int CB_AAK  = 2;
  localparam int CB_IFLG = 3;
  localparam int CB_STP  = 4;
  localparam int CB_STA  = 5;
  localparam int CB_ENAB = 6;
  localparam int CB_CE   = 7;

  // outcome code of a byte step from its kind and the acknowledge seen on the line
  function automatic logic [7:0] step_code(xfer_e k, logic ack);
    case (k)
      K_AW:    return ack ? ST_AW_ACK : ST_AW_NAK;
      K_AR:    return ack ? ST_AR_ACK : ST_AR_NAK;
      K_TX:    return ack ? ST_TX_ACK : ST_TX_NAK;
      default: return ack ? ST_RX_ACK : ST_RX_NAK;
    endcase
  endfunction

  function automatic xfer_e pick_kind(logic addr_next, logic rd_mode, logic rw_bit);
    if (addr_next) return rw_bit ? K_AR : K_AW;
    return rd_mode ? K_RX : K_TX;
  endfunction

  function automatic logic code_legal(logic [7:0] c);
    case (c)
      ST_BERR, ST_START, ST_RSTART, ST_AW_ACK, ST_AW_NAK, ST_TX_ACK, ST_TX_NAK,
      ST_ARB, ST_AR_ACK, ST_AR_NAK, ST_RX_ACK, ST_RX_NAK, ST_IDLE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ibe_shreg.sv
module ibe_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/ibe_bitctl.sv
module ibe_bitctl
  import ibe_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    go,
  input  bit_op_e op_i,
  input  logic    tx_i,
  input  logic    chk_i,
  input  logic    sda_i,
  output logic    scl_low_o,
  output logic    sda_low_o,
  output logic    done_o,
  output logic    rx_o,
  output logic    arb_o,
  output logic    berr_o
);
  logic       active;
  logic [1:0] step;
  bit_op_e    op_q;
  logic       tx_q, chk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; step <= '0; op_q <= OP_BIT; tx_q <= 1'b1; chk_q <= 1'b0;
      scl_low_o <= 1'b0; sda_low_o <= 1'b0;
      done_o <= 1'b0; rx_o <= 1'b1; arb_o <= 1'b0; berr_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      arb_o  <= 1'b0;
      berr_o <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1; step <= '0; op_q <= op_i; tx_q <= tx_i; chk_q <= chk_i;
        end
      end else if (tick) begin
        step <= step + 2'd1;
        case (op_q)
          OP_START: case (step)
            2'd0: sda_low_o <= 1'b0;
            2'd1: scl_low_o <= 1'b0;
            2'd2: if (!sda_i) begin
                    scl_low_o <= 1'b0; sda_low_o <= 1'b0;
                    berr_o <= 1'b1; done_o <= 1'b1; active <= 1'b0;
                  end else sda_low_o <= 1'b1;
            default: begin scl_low_o <= 1'b1; done_o <= 1'b1; active <= 1'b0; end
          endcase
          OP_STOP: case (step)
            2'd0: begin scl_low_o <= 1'b1; sda_low_o <= 1'b1; end
            2'd1: scl_low_o <= 1'b0;
            2'd2: sda_low_o <= 1'b0;
            default: begin done_o <= 1'b1; active <= 1'b0; end
          endcase
          default: case (step)
            2'd0: begin scl_low_o <= 1'b1; sda_low_o <= ~tx_q; end
            2'd1: scl_low_o <= 1'b0;
            2'd2: begin
                    rx_o <= sda_i;
                    if (chk_q && tx_q && !sda_i) begin
                      scl_low_o <= 1'b0; sda_low_o <= 1'b0;
                      arb_o <= 1'b1; done_o <= 1'b1; active <= 1'b0;
                    end
                  end
            default: begin scl_low_o <= 1'b1; done_o <= 1'b1; active <= 1'b0; end
          endcase
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_step_engine.sv
module i2c_step_engine
  import ibe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] data_o,
  output logic [7:0]        ctl_o,
  output logic [7:0]        status_o,
  output logic              scl_low_o,
  output logic              sda_low_o,
  input  logic              sda_i
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  typedef enum logic [2:0] {B_IDLE, B_START, B_STOP, B_BITS, B_ACK} bstate_e;

  bstate_e           bstate_q;
  xfer_e             kind_q, kind_nx;
  logic [DATA_W-1:0] data_q, sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              aak_q, iflg_q, stp_q, sta_q, enab_q, ce_q;
  logic              owned_q, addr_next_q, rd_mode_q;
  logic              bit_go_q, bit_tx_q, bit_chk_q;
  bit_op_e           bit_op_q;
  logic              bit_done, bit_rx, bit_arb, bit_berr;

  // named events used by the engine and by the bound checker
  logic ctl_wr, go_ok, launch_start, launch_stop, launch_byte, sh_shift, stop_fin;

  always_comb begin
    ctl_wr       = (bstate_q == B_IDLE) && reg_wr && reg_sel;
    go_ok        = ctl_wr && reg_wdata[CB_ENAB] && !(iflg_q && reg_wdata[CB_IFLG]);
    launch_start = go_ok && reg_wdata[CB_STA];
    launch_stop  = go_ok && !reg_wdata[CB_STA] && reg_wdata[CB_STP];
    launch_byte  = go_ok && !reg_wdata[CB_STA] && !reg_wdata[CB_STP] && owned_q;
    kind_nx      = pick_kind(addr_next_q, rd_mode_q, data_q[0]);
    sh_shift     = (bstate_q == B_BITS) && bit_done && !bit_arb;
    stop_fin     = (bstate_q == B_STOP) && bit_done;
  end

  ibe_shreg #(.W(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(launch_byte), .load_val(data_q),
    .shift(sh_shift), .din(bit_rx), .q(sh_q)
  );

  ibe_bitctl u_bit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(bit_go_q), .op_i(bit_op_q),
    .tx_i(bit_tx_q), .chk_i(bit_chk_q), .sda_i(sda_i),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .done_o(bit_done),
    .rx_o(bit_rx), .arb_o(bit_arb), .berr_o(bit_berr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bstate_q <= B_IDLE; kind_q <= K_AW; data_q <= '0; cnt_q <= '0;
      status_o <= ST_IDLE;
      {ce_q, enab_q, sta_q, stp_q, iflg_q, aak_q} <= '0;
      owned_q <= 1'b0; addr_next_q <= 1'b0; rd_mode_q <= 1'b0;
      bit_go_q <= 1'b0; bit_op_q <= OP_BIT; bit_tx_q <= 1'b1; bit_chk_q <= 1'b0;
    end else begin
      bit_go_q <= 1'b0;
      case (bstate_q)
        B_IDLE: begin
          if (reg_wr && !reg_sel) data_q <= reg_wdata;
          if (ctl_wr) begin
            aak_q  <= reg_wdata[CB_AAK];
            stp_q  <= reg_wdata[CB_STP];
            sta_q  <= reg_wdata[CB_STA];
            enab_q <= reg_wdata[CB_ENAB];
            ce_q   <= reg_wdata[CB_CE];
            iflg_q <= iflg_q & reg_wdata[CB_IFLG];
          end
          if (launch_start) begin
            bstate_q <= B_START; status_o <= ST_IDLE;
            bit_go_q <= 1'b1; bit_op_q <= OP_START; bit_tx_q <= 1'b1; bit_chk_q <= 1'b0;
          end else if (launch_stop) begin
            bstate_q <= B_STOP; status_o <= ST_IDLE;
            bit_go_q <= 1'b1; bit_op_q <= OP_STOP; bit_tx_q <= 1'b1; bit_chk_q <= 1'b0;
          end else if (launch_byte) begin
            bstate_q <= B_BITS; status_o <= ST_IDLE; kind_q <= kind_nx; cnt_q <= '0;
            bit_go_q <= 1'b1; bit_op_q <= OP_BIT;
            bit_tx_q  <= (kind_nx == K_RX) ? 1'b1 : data_q[DATA_W-1];
            bit_chk_q <= (kind_nx != K_RX);
          end
        end
        B_START: if (bit_done) begin
          bstate_q <= B_IDLE; sta_q <= 1'b0; iflg_q <= 1'b1;
          if (bit_berr) begin
            status_o <= ST_BERR; owned_q <= 1'b0;
          end else begin
            status_o <= owned_q ? ST_RSTART : ST_START;
            owned_q <= 1'b1; addr_next_q <= 1'b1;
          end
        end
        B_STOP: if (bit_done) begin
          bstate_q <= B_IDLE; stp_q <= 1'b0; owned_q <= 1'b0; status_o <= ST_IDLE;
        end
        B_BITS: if (bit_done) begin
          if (bit_arb) begin
            bstate_q <= B_IDLE; status_o <= ST_ARB; owned_q <= 1'b0; iflg_q <= 1'b1;
          end else if (cnt_q == LAST_BIT) begin
            bstate_q <= B_ACK;
            bit_go_q <= 1'b1; bit_op_q <= OP_BIT; bit_chk_q <= 1'b0;
            bit_tx_q <= (kind_q == K_RX) ? ~aak_q : 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            bit_go_q <= 1'b1; bit_op_q <= OP_BIT;
            bit_tx_q  <= (kind_q == K_RX) ? 1'b1 : sh_q[DATA_W-2];
            bit_chk_q <= (kind_q != K_RX);
          end
        end
        default: if (bit_done) begin
          bstate_q <= B_IDLE; iflg_q <= 1'b1; addr_next_q <= 1'b0;
          status_o <= step_code(kind_q, !bit_rx);
          if (kind_q == K_AR) rd_mode_q <= 1'b1;
          if (kind_q == K_AW) rd_mode_q <= 1'b0;
          if (kind_q == K_RX) data_q <= sh_q;
        end
      endcase
    end
  end

  assign data_o = data_q;
  assign ctl_o  = {ce_q, enab_q, sta_q, stp_q, iflg_q, aak_q, 2'b00};

endmodule

// File: rtl/ibe_checks.sv
module ibe_checks
  import ibe_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       iflg,
  input logic       owned,
  input logic       scl_low,
  input logic       sda_low,
  input logic [7:0] status,
  input logic       bit_done,
  input logic       bit_arb,
  input logic       stop_fin
);
  a_r11_scl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (iflg && owned) |-> scl_low);

  a_r11_flag_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iflg) |-> $past(bit_done));

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    bit_arb |=> (!scl_low && !sda_low && status == ST_ARB));

  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_fin |=> (!owned && !scl_low && !sda_low && status == ST_IDLE));

  a_r13_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    code_legal(status));
endmodule

bind i2c_step_engine ibe_checks u_chk (
  .clk(clk), .rst_n(rst_n), .iflg(iflg_q), .owned(owned_q),
  .scl_low(scl_low_o), .sda_low(sda_low_o), .status(status_o),
  .bit_done(bit_done), .bit_arb(bit_arb), .stop_fin(stop_fin)
);

// File: tb/i2c_step_engine_test.sv
`timescale 1ns/1ps
module i2c_step_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic reg_wr = 1'b0;
  logic reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] data_o, ctl_o, status_o;
  logic scl_low_o, sda_low_o;
  logic s_low = 1'b0;
  logic force_low = 1'b0;
  wire  sda_w = ~(sda_low_o | s_low | force_low);
  wire  scl_w = ~scl_low_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  i2c_step_engine uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .data_o(data_o), .ctl_o(ctl_o), .status_o(status_o),
    .scl_low_o(scl_low_o), .sda_low_o(sda_low_o), .sda_i(sda_w)
  );

  always #2.5 clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick = (tdiv == 0);
  end

  // behavioural target on the resolved lines
  logic ack_addr = 1'b1, ack_data = 1'b1, m_ack = 1'b0, stx = 1'b0;
  logic pscl = 1'b1, psda = 1'b1;
  logic [7:0] sh = '0;
  logic [7:0] cap [4];
  logic [7:0] rdq [4];
  int bitn = -1, byten = 0, rd_idx = 0, starts = 0, stops = 0, ncap = 0;

  always @(negedge clk) begin
    if (scl_w && psda && !sda_w) begin
      starts++; bitn = -1; byten = 0; stx = 0; s_low = 0;
    end else if (scl_w && !psda && sda_w) begin
      stops++; bitn = -1; stx = 0; s_low = 0;
    end else if (!pscl && scl_w) begin
      if (bitn >= 0 && bitn < 8) sh = {sh[6:0], sda_w};
      else if (bitn == 8 && stx) m_ack = !sda_w;
    end else if (pscl && !scl_w) begin
      if (bitn < 0) bitn = 0;
      else if (bitn < 8) begin
        bitn++;
        if (bitn < 8) begin
          if (stx) s_low = !rdq[rd_idx][7-bitn];
        end else if (stx) s_low = 0;
        else begin
          if (byten < 4) cap[byten] = sh;
          ncap++;
          s_low = (byten == 0) ? ack_addr : ack_data;
        end
      end else begin
        bitn = 0;
        if (stx) begin
          if (m_ack) begin rd_idx++; s_low = !rdq[rd_idx][7]; end
          else begin stx = 0; s_low = 0; end
        end else begin
          s_low = 0;
          if (byten == 0 && sh[0] && ack_addr) begin stx = 1; rd_idx = 0; s_low = !rdq[0][7]; end
          byten++;
        end
      end
    end
    pscl = scl_w; psda = sda_w;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic sel, input logic [7:0] v);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic wait_flag();
    int n = 0;
    while (!ctl_o[3] && n < 4000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_stp();
    int n = 0;
    while (ctl_o[4] && n < 4000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic do_start(input logic [7:0] exp_code, input string tag);
    put(1, 8'h60); wait_flag();
    chk(tag, status_o, exp_code);
  endtask

  task automatic do_byte(input logic [7:0] d, input logic [7:0] ctl, input logic [7:0] exp_code, input string tag);
    put(0, d); put(1, ctl); wait_flag();
    chk(tag, status_o, exp_code);
  endtask

  task automatic do_stop();
    put(1, 8'h50); wait_stp();
    chk("R8 status after stop", status_o, 8'hF8);
    chk("R8 control after stop", ctl_o, 8'h40);
    chk("R8 lines released", {scl_low_o, sda_low_o}, 2'b00);
  endtask

  task automatic t_reset();
    chk("R1 control reset", ctl_o, 8'h00);
    chk("R1 status reset", status_o, 8'hF8);
    chk("R1 lines released", {scl_low_o, sda_low_o}, 2'b00);
  endtask

  task automatic t_no_enab();
    put(1, 8'h20); repeat (80) @(negedge clk);
    chk("R12 no start seen", starts, 0);
    chk("R12 flag clear", ctl_o[3], 1'b0);
    chk("R12 scl released", scl_low_o, 1'b0);
  endtask

  task automatic t_write_path();
    do_start(8'h08, "R2 start code");
    chk("R2 start on bus", starts, 1);
    chk("R2 control flag set, STA clear", ctl_o, 8'h48);
    do_byte(8'hA0, 8'h40, 8'h18, "R4 address write ACK");
    chk("R4 address captured MSB first", cap[0], 8'hA0);
    put(1, 8'h48); repeat (100) @(negedge clk);
    chk("R11 flag kept", ctl_o[3], 1'b1);
    chk("R11 status unchanged", status_o, 8'h18);
    chk("R11 scl held low", scl_low_o, 1'b1);
    chk("R11 no extra byte", ncap, 1);
    do_byte(8'h3C, 8'h40, 8'h28, "R6 data ACK");
    chk("R6 data captured", cap[1], 8'h3C);
    ack_data = 0;
    do_byte(8'h5A, 8'h40, 8'h30, "R6 data NAK");
    chk("R6 second data captured", cap[2], 8'h5A);
    ack_data = 1;
  endtask

  task automatic t_read_path();
    rdq[0] = 8'hC5; rdq[1] = 8'h3B;
    do_start(8'h10, "R3 repeated start code");
    chk("R3 start seen again", starts, 2);
    do_byte(8'hA1, 8'h40, 8'h40, "R5 address read ACK");
    put(1, 8'h44); wait_flag();
    chk("R7 ACK code", status_o, 8'h50);
    chk("R7 first byte", data_o, 8'hC5);
    chk("R7 ack returned", m_ack, 1'b1);
    put(1, 8'h40); wait_flag();
    chk("R7 NAK code", status_o, 8'h58);
    chk("R7 last byte", data_o, 8'h3B);
    chk("R7 nak returned", m_ack, 1'b0);
    do_stop();
    chk("R8 stop on bus", stops, 1);
  endtask

  task automatic t_nak_addrs();
    ack_addr = 0;
    do_start(8'h08, "R2 start after stop");
    do_byte(8'hA0, 8'h40, 8'h20, "R4 address write NAK");
    do_stop();
    do_start(8'h08, "R2 start again");
    do_byte(8'hA1, 8'h40, 8'h48, "R5 address read NAK");
    do_stop();
    ack_addr = 1;
  endtask

  task automatic t_arb_berr();
    do_start(8'h08, "R2 start before contention");
    force_low = 1;
    do_byte(8'hA0, 8'h40, 8'h38, "R9 arbitration code");
    chk("R9 lines released", {scl_low_o, sda_low_o}, 2'b00);
    chk("R9 flag set", ctl_o[3], 1'b1);
    put(1, 8'h60); wait_flag();
    chk("R10 bus error code", status_o, 8'h00);
    chk("R10 lines released", {scl_low_o, sda_low_o}, 2'b00);
    force_low = 0;
    repeat (20) @(negedge clk);
    do_start(8'h08, "R13 fresh start after error");
    chk("R13 legal code after recovery", {31'd0, ((status_o == 8'h08) || (status_o == 8'hF8))}, 32'd1);
    do_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_no_enab();
    t_write_path();
    t_read_path();
    t_nak_addrs();
    t_arb_berr();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule